// File: doc/BRIEF.md
# Legacy Memory Region Routing Decoder

This block steers host cycles that fall in the upper part of the first megabyte of the address space. For every host cycle it receives the address, a write flag, a code-fetch flag and a flag telling whether the processor is in system management mode. One clock later it reports whether that cycle belongs to system DRAM, has to be forwarded to the PCI bus, or must be rejected as invalid. Addresses at or above the one-megabyte line are reported as not decoded.

Three 8-bit control registers, written and read over a simple register port, set the routing. Two of them carry read and write steering for eight 16 KB option-ROM segments between C0000h and DFFFFh. The third carries the steering for the two 64 KB BIOS segments and the system-management mode for the A0000h–BFFFFh window. Two status outputs say whether any BIOS segment is shadowed for reads or for writes.

Top module: `legacy_route_dec`

## Requirements
- R1: After reset all three control registers read 0, rt_vld is 0, bios_rd_shadow and bios_wr_shadow are 0, and every segment from C0000h to FFFFFh routes both reads and writes to PCI.
- R2: The control registers sit at register offsets 10h (segments C0000h–CFFFFh), 11h (segments D0000h–DFFFFh) and 12h (BIOS and SMM control). A write takes effect from the next clock. cfg_rdata shows the stored value of the addressed register at once. A read of any other offset returns 0, and a write to any other offset changes no register.
- R3: rt_vld is 1 exactly in the cycle after one in which host_vld was 1, and rt_code then holds that cycle's route: 0 not decoded, 1 DRAM, 2 PCI, 3 invalid. rt_code is 0 whenever rt_vld is 0.
- R4: Addresses below A0000h always route to DRAM.
- R5: Addresses at or above 100000h return rt_code 0.
- R6: C0000h–DFFFFh is split into eight 16 KB segments. Segment k (k = address bits 16:14) takes its field from bits 2(k mod 4)+1 : 2(k mod 4) of offset 10h for k < 4 and of offset 11h for k >= 4.
- R7: In a segment field, bit 1 set sends reads and code fetches to DRAM, and bit 0 set sends writes to DRAM. A clear bit sends that direction to PCI. host_wr selects the direction.
- R8: E0000h–EFFFFh uses bits 7:6 of offset 12h and F0000h–FFFFFh uses bits 5:4, with the field meaning of R7.
- R9: Bits 1:0 of offset 12h set the mode of A0000h–BFFFFh. In mode 0, SMM cycles go to DRAM and other cycles to PCI. In mode 1, all cycles go to DRAM. In mode 2, SMM cycles are invalid, non-SMM code fetches go to DRAM and non-SMM data cycles go to PCI. In mode 3, SMM cycles go to DRAM and other cycles are invalid.
- R10: bios_rd_shadow is the OR of bits 7 and 5 of offset 12h, and bios_wr_shadow is the OR of bits 6 and 4. Both change only in the clock after a register write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register offset |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Stored value at cfg_addr, 0 if unmapped |
| host_vld | input | 1 | Host cycle present |
| host_addr | input | 32 | Host cycle byte address |
| host_wr | input | 1 | 1 for a write cycle |
| host_code | input | 1 | 1 for a code fetch |
| host_smm | input | 1 | 1 while in system management mode |
| rt_vld | output | 1 | Route result valid |
| rt_code | output | 2 | Route: 0 none, 1 DRAM, 2 PCI, 3 invalid |
| bios_rd_shadow | output | 1 | A BIOS segment reads from DRAM |
| bios_wr_shadow | output | 1 | A BIOS segment writes to DRAM |

## Verification
The assertions assume that the input flags are driven to known levels in every cycle after reset. They also assume that the register port and the host port may be active in the same cycle, so a route is judged against the settings held before the edge. The bench keeps inputs at defined values from time zero. It changes them only on the falling edge, and it spreads random addresses across every region and across both sides of each segment boundary. This keeps every assertion's premise true while reaching each mode and field value.

// File: rtl/legacy_route_pkg.sv
// Shared types and constants for the legacy memory region routing decoder.
// Assumes byte addresses and a one-megabyte legacy space.
package legacy_route_pkg;

    localparam int NUM_CTL_REGS = 3;
    localparam int CTL_W        = 8;
    localparam int NUM_SEG16    = 8;
    localparam int SEG_FIELD_W  = 2;

    typedef enum logic [1:0] {
        ROUTE_NONE  = 2'd0,
        ROUTE_DRAM  = 2'd1,
        ROUTE_PCI   = 2'd2,
        ROUTE_INVAL = 2'd3
    } route_e;

    typedef enum logic [2:0] {
        RGN_LOW   = 3'd0,
        RGN_SMM   = 3'd1,
        RGN_SEG16 = 3'd2,
        RGN_SEG64 = 3'd3,
        RGN_OUT   = 3'd4
    } region_e;

endpackage

// File: rtl/lrd_cfg_regs.sv
// Control register file: NUM_CTL_REGS byte registers at parameter offsets.
// Assumes one write per cycle; unmapped writes are dropped, unmapped reads give 0.
module lrd_cfg_regs
    import legacy_route_pkg::*;
#(
    parameter int OFS_W = 8,
    parameter logic [NUM_CTL_REGS*OFS_W-1:0] OFS_LIST = {8'h12, 8'h11, 8'h10}
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [OFS_W-1:0]                addr,
    input  logic [CTL_W-1:0]                wdata,
    output logic [CTL_W-1:0]                rdata,
    output logic [NUM_CTL_REGS*CTL_W-1:0]   ctl_flat
);

    logic [CTL_W-1:0] ctl_q [NUM_CTL_REGS];

    for (genvar i = 0; i < NUM_CTL_REGS; i++) begin : g_reg
        // Hold one control byte; load it when its offset is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctl_q[i] <= '0;
            else if (wr_en && (addr == OFS_LIST[i*OFS_W +: OFS_W]))
                ctl_q[i] <= wdata;
        end
        assign ctl_flat[i*CTL_W +: CTL_W] = ctl_q[i];
    end

    // Return the addressed register, or zero for an unmapped offset.
    always_comb begin
        rdata = '0;
        for (int j = 0; j < NUM_CTL_REGS; j++)
            if (addr == OFS_LIST[j*OFS_W +: OFS_W])
                rdata = ctl_q[j];
    end

endmodule

// File: rtl/lrd_region_decode.sv
// Classifies a host address into a legacy region and picks the segment index.
// Assumes ADDR_W > 20; only bits 14 and up matter for classification.
module lrd_region_decode
    import legacy_route_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:14] addr_hi,
    output region_e            region,
    output logic [2:0]         seg16_idx,
    output logic               seg64_is_f
);

    localparam int HI_W = ADDR_W - 20;

    logic       above_1m;
    logic [5:0] blk16;

    assign above_1m   = |addr_hi[ADDR_W-1:20];
    assign blk16      = addr_hi[19:14];
    assign seg16_idx  = addr_hi[16:14];
    assign seg64_is_f = addr_hi[16];

    // Map the 16 KB block number to its region.
    always_comb begin
        if (above_1m)
            region = RGN_OUT;
        else if (blk16 < 6'h28)
            region = RGN_LOW;
        else if (blk16 < 6'h30)
            region = RGN_SMM;
        else if (blk16 < 6'h38)
            region = RGN_SEG16;
        else
            region = RGN_SEG64;
    end

    if (HI_W < 1) begin : g_bad_width
        $error("ADDR_W must exceed 20");
    end

endmodule

// File: rtl/lrd_route_select.sv
// Turns a region, the control fields and the cycle flags into a route code.
// Assumes the fields are stable for the cycle being judged.
module lrd_route_select
    import legacy_route_pkg::*;
(
    input  region_e                          region,
    input  logic [2:0]                       seg16_idx,
    input  logic                             seg64_is_f,
    input  logic [NUM_SEG16*SEG_FIELD_W-1:0] seg16_fields,
    input  logic [3:0]                       seg64_fields,
    input  logic [1:0]                       smm_mode,
    input  logic                             is_wr,
    input  logic                             is_code,
    input  logic                             in_smm,
    output route_e                           route
);

    logic [SEG_FIELD_W-1:0] seg_field [NUM_SEG16];
    logic [SEG_FIELD_W-1:0] sel16;
    logic [SEG_FIELD_W-1:0] sel64;
    route_e                 smm_route;

    for (genvar k = 0; k < NUM_SEG16; k++) begin : g_field
        assign seg_field[k] = seg16_fields[k*SEG_FIELD_W +: SEG_FIELD_W];
    end

    assign sel16 = seg_field[seg16_idx];
    assign sel64 = seg64_is_f ? seg64_fields[1:0] : seg64_fields[3:2];

    // Steer the A0000h-BFFFFh window by SMM mode, SMM state and fetch type.
    always_comb begin
        unique case (smm_mode)
            2'd0:    smm_route = in_smm ? ROUTE_DRAM : ROUTE_PCI;
            2'd1:    smm_route = ROUTE_DRAM;
            2'd2:    smm_route = in_smm ? ROUTE_INVAL
                               : (is_code ? ROUTE_DRAM : ROUTE_PCI);
            default: smm_route = in_smm ? ROUTE_DRAM : ROUTE_INVAL;
        endcase
    end

    // Choose the final route by region; shadow fields use bit 1 for reads, bit 0 for writes.
    always_comb begin
        unique case (region)
            RGN_LOW:   route = ROUTE_DRAM;
            RGN_SMM:   route = smm_route;
            RGN_SEG16: route = (is_wr ? sel16[0] : sel16[1]) ? ROUTE_DRAM : ROUTE_PCI;
            RGN_SEG64: route = (is_wr ? sel64[0] : sel64[1]) ? ROUTE_DRAM : ROUTE_PCI;
            default:   route = ROUTE_NONE;
        endcase
    end

endmodule

// File: rtl/legacy_route_dec.sv
// Top of the legacy memory region routing decoder. Registers the route one
// clock after host_vld and exposes the BIOS shadow summary.
// Assumes a synchronous active-low reset and inputs stable around the clock edge.
module legacy_route_dec
    import legacy_route_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 8,
    parameter logic [OFS_W-1:0] OFS_SEG_LO = 8'h10,
    parameter logic [OFS_W-1:0] OFS_SEG_HI = 8'h11,
    parameter logic [OFS_W-1:0] OFS_TOP    = 8'h12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [OFS_W-1:0]  cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              host_vld,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_code,
    input  logic              host_smm,
    output logic              rt_vld,
    output logic [1:0]        rt_code,
    output logic              bios_rd_shadow,
    output logic              bios_wr_shadow
);

    localparam logic [NUM_CTL_REGS*OFS_W-1:0] OFS_LIST = {OFS_TOP, OFS_SEG_HI, OFS_SEG_LO};

    logic [NUM_CTL_REGS*CTL_W-1:0] ctl_flat;
    logic [CTL_W-1:0]              top_ctl;
    region_e                       region;
    logic [2:0]                    seg16_idx;
    logic                          seg64_is_f;
    route_e                        route_nxt;
    logic                          vld_q;
    route_e                        route_q;

    lrd_cfg_regs #(
        .OFS_W    (OFS_W),
        .OFS_LIST (OFS_LIST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .ctl_flat (ctl_flat)
    );

    assign top_ctl = ctl_flat[2*CTL_W +: CTL_W];

    lrd_region_decode #(
        .ADDR_W (ADDR_W)
    ) u_rgn (
        .addr_hi    (host_addr[ADDR_W-1:14]),
        .region     (region),
        .seg16_idx  (seg16_idx),
        .seg64_is_f (seg64_is_f)
    );

    lrd_route_select u_sel (
        .region       (region),
        .seg16_idx    (seg16_idx),
        .seg64_is_f   (seg64_is_f),
        .seg16_fields (ctl_flat[2*CTL_W-1:0]),
        .seg64_fields (top_ctl[7:4]),
        .smm_mode     (top_ctl[1:0]),
        .is_wr        (host_wr),
        .is_code      (host_code),
        .in_smm       (host_smm),
        .route        (route_nxt)
    );

    // Capture the route for each presented host cycle; idle cycles give NONE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= 1'b0;
            route_q <= ROUTE_NONE;
        end else begin
            vld_q   <= host_vld;
            route_q <= host_vld ? route_nxt : ROUTE_NONE;
        end
    end

    assign rt_vld         = vld_q;
    assign rt_code        = route_q;
    assign bios_rd_shadow = top_ctl[7] | top_ctl[5];
    assign bios_wr_shadow = top_ctl[6] | top_ctl[4];

endmodule

// File: rtl/lrd_checker.sv
// Temporal checks on the decoder ports, bound to every legacy_route_dec instance.
// Assumes inputs hold known values after reset.
module lrd_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic              host_vld,
    input logic [ADDR_W-1:0] host_addr,
    input logic              rt_vld,
    input logic [1:0]        rt_code,
    input logic              bios_rd_shadow,
    input logic              bios_wr_shadow
);

    logic beyond_1m;
    logic outside_ab;
    assign beyond_1m  = (host_addr >> 20) != '0;
    assign outside_ab = beyond_1m || (host_addr[19:0] < 20'hA0000) || (host_addr[19:0] > 20'hBFFFF);

    // R3
    vld_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_vld |=> rt_vld);

    // R3
    idle_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_vld |=> (!rt_vld && rt_code == 2'd0));

    // R4
    low_dram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_vld && !beyond_1m && host_addr[19:0] < 20'hA0000) |=> rt_code == 2'd1);

    // R5
    out_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_vld && beyond_1m) |=> rt_code == 2'd0);

    // R9
    inval_only_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_vld && outside_ab) |=> rt_code != 2'd3);

    // R10
    bios_rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(bios_rd_shadow));

    // R10
    bios_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(bios_wr_shadow));

endmodule

bind legacy_route_dec lrd_checker #(.ADDR_W(ADDR_W)) u_lrd_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_wr         (cfg_wr),
    .host_vld       (host_vld),
    .host_addr      (host_addr),
    .rt_vld         (rt_vld),
    .rt_code        (rt_code),
    .bios_rd_shadow (bios_rd_shadow),
    .bios_wr_shadow (bios_wr_shadow)
);

// File: tb/legacy_route_dec_bench.sv
// Self-checking bench: directed corners plus seeded random cycles against a bench model.
module legacy_route_dec_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        host_vld = 1'b0;
    logic [31:0] host_addr = 32'h0;
    logic        host_wr = 1'b0;
    logic        host_code = 1'b0;
    logic        host_smm = 1'b0;
    logic        rt_vld;
    logic [1:0]  rt_code;
    logic        bios_rd_shadow;
    logic        bios_wr_shadow;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [7:0] m_lo = 8'h0, m_hi = 8'h0, m_top = 8'h0;

    legacy_route_dec u_legacy_route_dec (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .host_vld(host_vld), .host_addr(host_addr), .host_wr(host_wr),
        .host_code(host_code), .host_smm(host_smm),
        .rt_vld(rt_vld), .rt_code(rt_code),
        .bios_rd_shadow(bios_rd_shadow), .bios_wr_shadow(bios_wr_shadow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [1:0] fld_route(logic [1:0] f, logic wr);
        return (wr ? f[0] : f[1]) ? 2'd1 : 2'd2;
    endfunction

    // Expected route from R4..R9.
    function automatic logic [1:0] exp_route(logic [31:0] a, logic wr, logic code, logic smm);
        logic [15:0] seg;
        logic [2:0]  k;
        seg = {m_hi, m_lo};
        if (a >= 32'h100000) return 2'd0;
        if (a < 32'hA0000)   return 2'd1;
        if (a < 32'hC0000) begin
            case (m_top[1:0])
                2'd0: return smm ? 2'd1 : 2'd2;
                2'd1: return 2'd1;
                2'd2: return smm ? 2'd3 : (code ? 2'd1 : 2'd2);
                default: return smm ? 2'd1 : 2'd3;
            endcase
        end
        if (a < 32'hE0000) begin
            k = 3'((a - 32'hC0000) / 32'h4000);
            return fld_route(seg[k*2 +: 2], wr);
        end
        if (a < 32'hF0000) return fld_route(m_top[7:6], wr);
        return fld_route(m_top[5:4], wr);
    endfunction

    task automatic check(logic [31:0] act, logic [31:0] expv, string req);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic reg_write(logic [7:0] ofs, logic [7:0] val);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = ofs; cfg_wdata = val;
        @(negedge clk);
        cfg_wr = 1'b0;
        case (ofs)
            8'h10: m_lo = val;
            8'h11: m_hi = val;
            8'h12: m_top = val;
            default: ;
        endcase
    endtask

    task automatic reg_check(logic [7:0] ofs, logic [7:0] expv, string req);
        cfg_addr = ofs;
        #1;
        check(32'(cfg_rdata), 32'(expv), req);
    endtask

    task automatic host_cycle(logic [31:0] a, logic wr, logic code, logic smm, string req);
        @(negedge clk);
        host_vld = 1'b1; host_addr = a; host_wr = wr; host_code = code; host_smm = smm;
        @(negedge clk);
        host_vld = 1'b0;
        check(32'({rt_vld, rt_code}), 32'({1'b1, exp_route(a, wr, code, smm)}), req);
    endtask

    function automatic logic [31:0] rand_addr();
        int sel;
        sel = $urandom_range(0, 5);
        case (sel)
            0: return $urandom_range(0, 32'h9FFFF);
            1: return $urandom_range(32'hA0000, 32'hBFFFF);
            2, 3: return $urandom_range(32'hC0000, 32'hDFFFF);
            4: return $urandom_range(32'hE0000, 32'hFFFFF);
            default: return $urandom_range(32'h100000, 32'hFFFFFFFF);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20250601));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(32'(rt_vld), 0, "R1");
        check(32'({bios_rd_shadow, bios_wr_shadow}), 0, "R1");
        reg_check(8'h10, 8'h00, "R1");
        reg_check(8'h11, 8'h00, "R1");
        reg_check(8'h12, 8'h00, "R1");
        host_cycle(32'hC0000, 1'b0, 1'b0, 1'b0, "R1");
        host_cycle(32'hF8000, 1'b1, 1'b0, 1'b0, "R1");

        // R3 idle gives no result
        @(negedge clk);
        check(32'({rt_vld, rt_code}), 0, "R3");

        // R2 register access and unmapped offsets
        reg_write(8'h10, 8'hA5);
        reg_check(8'h10, 8'hA5, "R2");
        reg_write(8'h33, 8'hFF);
        reg_check(8'h33, 8'h00, "R2");
        reg_check(8'h10, 8'hA5, "R2");
        reg_check(8'h11, 8'h00, "R2");
        reg_check(8'h12, 8'h00, "R2");

        // R4 / R5 boundaries
        host_cycle(32'h9FFFF, 1'b1, 1'b0, 1'b1, "R4");
        host_cycle(32'h00000, 1'b0, 1'b1, 1'b0, "R4");
        host_cycle(32'h100000, 1'b0, 1'b0, 1'b0, "R5");
        host_cycle(32'hFFFFFFFF, 1'b1, 1'b0, 1'b1, "R5");

        // R6 / R7 each segment with distinct fields
        reg_write(8'h10, 8'b10_01_11_00);
        reg_write(8'h11, 8'b00_11_01_10);
        for (int k = 0; k < 8; k++) begin
            host_cycle(32'hC0000 + k*32'h4000, 1'b0, 1'b0, 1'b0, "R6");
            host_cycle(32'hC3FFF + k*32'h4000, 1'b1, 1'b0, 1'b0, "R7");
            host_cycle(32'hC2000 + k*32'h4000, 1'b0, 1'b1, 1'b1, "R7");
        end

        // R8 / R10 BIOS segments and summary
        reg_write(8'h12, 8'b10_01_00_00);
        check(32'({bios_rd_shadow, bios_wr_shadow}), 32'b11, "R10");
        host_cycle(32'hE0000, 1'b0, 1'b0, 1'b0, "R8");
        host_cycle(32'hEFFFF, 1'b1, 1'b0, 1'b0, "R8");
        host_cycle(32'hF0000, 1'b0, 1'b0, 1'b0, "R8");
        host_cycle(32'hFFFFF, 1'b1, 1'b0, 1'b0, "R8");
        reg_write(8'h12, 8'b00_01_00_00);
        check(32'({bios_rd_shadow, bios_wr_shadow}), 32'b01, "R10");

        // R9 every mode, every flag combination
        for (int md = 0; md < 4; md++) begin
            reg_write(8'h12, 8'(md));
            for (int f = 0; f < 8; f++)
                host_cycle((f[0] ? 32'hBFFFF : 32'hA0000), f[2], f[1], f[0], "R9");
        end

        // Random mix (R3..R10)
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 9) == 0) begin
                reg_write(8'h10 + 8'($urandom_range(0, 3)), 8'($urandom));
                check(32'({bios_rd_shadow, bios_wr_shadow}),
                      32'({m_top[7] | m_top[5], m_top[6] | m_top[4]}), "R10");
            end
            host_cycle(rand_addr(), 1'($urandom), 1'($urandom), 1'($urandom), "R6");
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule